// File: doc/BRIEF.md
# Panel Self-Refresh Control FSM

This block decides, for one display pipe, when the attached panel may refresh itself from its own buffer and when the source must resume sending frames. Software programs a 32-bit control word through a simple write port. The word holds an enable, a self-clearing abort bit, a three-bit policy field, a one-shot frame-update request and a software entry request. The block watches a vertical-blank strobe and a strobe that marks writes able to change the framebuffer. It reports its current state and pulses a capture signal when a single fresh frame must be sent to the panel.

Three policies decide who owns the transitions. Under the manual policy the block never moves by itself. Under the software policy the entry-request bit moves it in and out. Under the hardware policy an idle-frame counter triggers entry, and framebuffer writes force an exit. A one-shot update starts at once and returns to the self-refresh state at the next vertical blank. The readback of its request bit only follows the written value at a vertical blank.

Top module: `selfrefresh_ctrl`

## Requirements
- R1: After reset every control field reads 0, `srState` is 2'b00 (inactive) and `captureFrame` is 0.
- R2: Readback places enable at bit 0, policy at bits 4:2 and entry request at bit 8; bit 1, bits 6:5 and bits 31:9 always read 0.
- R3: `srState` encodes inactive 2'b00, active 2'b01 and single-frame update 2'b10. With enable 0, or with policy 000 (manual) or a reserved policy 011..111, the state is inactive from the second clock edge after the write.
- R4: With enable 1 and policy 001 (software), a write that changes bit 8 from 0 to 1 makes the state active, and a write that changes it from 1 to 0 makes it inactive, both on the second clock edge after the write edge. Under any other policy bit 8 has no effect on the state.
- R5: With enable 1 and policy 010 (hardware), the state becomes active one edge after the IDLE_FRAMES-th consecutive vblank strobe with no framebuffer write (default 4). One vblank fewer leaves it inactive, and a framebuffer write restarts the count.
- R6: Under the hardware policy, a framebuffer write strobe while active makes the state inactive on that clock edge.
- R7: A write with bit 7 set, with enable 1 and policy 001 or 010, moves the state to single-frame update on the second edge after the write, without waiting for vblank. `captureFrame` is high for exactly that first cycle. Under the manual policy the request has no effect.
- R8: A single-frame update ends at the first vblank strobe, and the state is active from that clock edge.
- R9: Readback bit 7 takes the last written value of bit 7 only at a vblank strobe. Until then it keeps its old value.
- R10: A write with bit 1 set forces the inactive state on the second edge after the write and clears the idle count. The bit reads back 0, and the block does not re-enter from the still-set entry request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe for the control word |
| regWrData | input | 32 | Control word being written |
| vblank | input | 1 | One-cycle vertical-blank strobe |
| fbWrite | input | 1 | One-cycle strobe for a write that can change the framebuffer |
| regRdData | output | 32 | Readback of the control word |
| srState | output | 2 | Current self-refresh state |
| captureFrame | output | 1 | One-cycle pulse starting a single-frame update |

## Verification
A wrong state register shows on `srState` one edge after the event that should have moved it. Checks therefore sample the state one cycle after each write, vblank or framebuffer-write strobe. A wrong idle count shows only as entry one frame early or late, so the hardware-policy checks look at the state after both IDLE_FRAMES-1 and IDLE_FRAMES vblanks. A stale or early one-shot readback shows on bit 7 of `regRdData` between the write and the next vblank. A missing or doubled capture shows on `captureFrame` in the first and second cycles of the update.

// File: rtl/selfrefresh_pkg.sv
package selfrefresh_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_ACTIVE = 2'b01,
    ST_SFU    = 2'b10
  } srState_t;

  localparam logic [2:0] POL_MANUAL = 3'b000;
  localparam logic [2:0] POL_SW     = 3'b001;
  localparam logic [2:0] POL_HW     = 3'b010;

  localparam int BIT_ON      = 0;
  localparam int BIT_ABORT   = 1;
  localparam int BIT_POL_LO  = 2;
  localparam int BIT_ONESHOT = 7;
  localparam int BIT_ENTRY   = 8;

  typedef struct packed {
    logic idleClear;
    logic idleStep;
  } ctrlStrobes_t;

endpackage

// File: rtl/selfrefresh_regs.sv
module selfrefresh_regs
  import selfrefresh_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int IDLE_FRAMES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              vblank,
  input  ctrlStrobes_t      strobes,
  output logic              cfgOn,
  output logic [2:0]        cfgPolicy,
  output logic              abortPulse,
  output logic              oneShotReq,
  output logic              entryRise,
  output logic              entryFall,
  output logic              idleReached,
  output logic [DATA_W-1:0] regRdData
);

  localparam int CNT_W = $clog2(IDLE_FRAMES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(IDLE_FRAMES);

  logic             entryReq;
  logic             oneShotPending;
  logic             oneShotShown;
  logic [CNT_W-1:0] idleCount;
  logic             unusedWrBits;

  assign unusedWrBits = ^{regWrData[DATA_W-1:BIT_ENTRY+1], regWrData[6:5]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgOn          <= 1'b0;
      cfgPolicy      <= POL_MANUAL;
      entryReq       <= 1'b0;
      oneShotPending <= 1'b0;
      abortPulse     <= 1'b0;
      oneShotReq     <= 1'b0;
      entryRise      <= 1'b0;
      entryFall      <= 1'b0;
    end else if (regWrEn) begin
      cfgOn          <= regWrData[BIT_ON];
      cfgPolicy      <= regWrData[BIT_POL_LO +: 3];
      entryReq       <= regWrData[BIT_ENTRY];
      oneShotPending <= regWrData[BIT_ONESHOT];
      abortPulse     <= regWrData[BIT_ABORT];
      oneShotReq     <= regWrData[BIT_ONESHOT];
      entryRise      <= regWrData[BIT_ENTRY] & ~entryReq;
      entryFall      <= ~regWrData[BIT_ENTRY] & entryReq;
    end else begin
      abortPulse     <= 1'b0;
      oneShotReq     <= 1'b0;
      entryRise      <= 1'b0;
      entryFall      <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oneShotShown <= 1'b0;
    end else if (vblank) begin
      oneShotShown <= oneShotPending;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCount <= '0;
    end else if (strobes.idleClear) begin
      idleCount <= '0;
    end else if (strobes.idleStep && idleCount != CNT_MAX) begin
      idleCount <= idleCount + 1'b1;
    end
  end

  assign idleReached = (idleCount == CNT_MAX);

  always_comb begin
    regRdData                      = '0;
    regRdData[BIT_ON]              = cfgOn;
    regRdData[BIT_POL_LO +: 3]     = cfgPolicy;
    regRdData[BIT_ONESHOT]         = oneShotShown;
    regRdData[BIT_ENTRY]           = entryReq;
  end

  AST_IDLE_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    idleCount <= CNT_MAX); // R5

  AST_SHOWN_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !vblank |=> $stable(oneShotShown)); // R9

  AST_RISE_FALL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(entryRise && entryFall)); // R4

endmodule

// File: rtl/selfrefresh_fsm.sv
module selfrefresh_fsm
  import selfrefresh_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgOn,
  input  logic [2:0]   cfgPolicy,
  input  logic         abortPulse,
  input  logic         oneShotReq,
  input  logic         entryRise,
  input  logic         entryFall,
  input  logic         idleReached,
  input  logic         vblank,
  input  logic         fbWrite,
  output ctrlStrobes_t strobes,
  output srState_t     state,
  output logic         captureFrame
);

  srState_t nextState;
  logic     swMode;
  logic     hwMode;
  logic     autoOk;

  assign swMode = cfgOn && (cfgPolicy == POL_SW);
  assign hwMode = cfgOn && (cfgPolicy == POL_HW);
  assign autoOk = swMode || hwMode;

  always_comb begin
    nextState = state;
    if (abortPulse || !autoOk) begin
      nextState = ST_IDLE;
    end else if (oneShotReq) begin
      nextState = ST_SFU;
    end else if (swMode && entryFall) begin
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if ((swMode && entryRise) || (hwMode && idleReached)) nextState = ST_ACTIVE;
        end
        ST_ACTIVE: begin
          if (hwMode && fbWrite) nextState = ST_IDLE;
        end
        ST_SFU: begin
          if (vblank) nextState = ST_ACTIVE;
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      captureFrame <= 1'b0;
    end else begin
      state        <= nextState;
      captureFrame <= (nextState == ST_SFU) && oneShotReq;
    end
  end

  assign strobes.idleClear = abortPulse || !hwMode || fbWrite || (state != ST_IDLE);
  assign strobes.idleStep  = vblank;

  AST_CAPTURE_IN_SFU: assert property (@(posedge clk) disable iff (!rstN)
    captureFrame |-> (state == ST_SFU)); // R7

  AST_NOT_AUTO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !autoOk |=> (state == ST_IDLE)); // R3

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |=> (state == ST_IDLE)); // R10

  AST_SW_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (swMode && entryRise && state == ST_IDLE && !oneShotReq && !abortPulse)
      |=> (state == ST_ACTIVE)); // R4

  AST_FB_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (hwMode && state == ST_ACTIVE && fbWrite) |=> (state != ST_ACTIVE)); // R6

  AST_SFU_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SFU && vblank && autoOk && !abortPulse && !oneShotReq
      && !(swMode && entryFall)) |=> (state == ST_ACTIVE)); // R8

endmodule

// File: rtl/selfrefresh_ctrl.sv
module selfrefresh_ctrl
  import selfrefresh_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int IDLE_FRAMES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              vblank,
  input  logic              fbWrite,
  output logic [DATA_W-1:0] regRdData,
  output logic [1:0]        srState,
  output logic              captureFrame
);

  ctrlStrobes_t strobes;
  srState_t     state;
  logic         cfgOn;
  logic [2:0]   cfgPolicy;
  logic         abortPulse;
  logic         oneShotReq;
  logic         entryRise;
  logic         entryFall;
  logic         idleReached;

  selfrefresh_regs #(
    .DATA_W      (DATA_W),
    .IDLE_FRAMES (IDLE_FRAMES)
  ) uRegs (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regWrData   (regWrData),
    .vblank      (vblank),
    .strobes     (strobes),
    .cfgOn       (cfgOn),
    .cfgPolicy   (cfgPolicy),
    .abortPulse  (abortPulse),
    .oneShotReq  (oneShotReq),
    .entryRise   (entryRise),
    .entryFall   (entryFall),
    .idleReached (idleReached),
    .regRdData   (regRdData)
  );

  selfrefresh_fsm uFsm (
    .clk          (clk),
    .rstN         (rstN),
    .cfgOn        (cfgOn),
    .cfgPolicy    (cfgPolicy),
    .abortPulse   (abortPulse),
    .oneShotReq   (oneShotReq),
    .entryRise    (entryRise),
    .entryFall    (entryFall),
    .idleReached  (idleReached),
    .vblank       (vblank),
    .fbWrite      (fbWrite),
    .strobes      (strobes),
    .state        (state),
    .captureFrame (captureFrame)
  );

  assign srState = state;

endmodule

// File: tb/selfrefresh_ctrl_test.sv
module selfrefresh_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int IDLE_N     = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic        vblank = 1'b0;
  logic        fbWrite = 1'b0;
  logic [31:0] regRdData;
  logic [1:0]  srState;
  logic        captureFrame;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  selfrefresh_ctrl #(.DATA_W(32), .IDLE_FRAMES(IDLE_N)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .vblank(vblank), .fbWrite(fbWrite), .regRdData(regRdData),
    .srState(srState), .captureFrame(captureFrame)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writeReg(logic [31:0] d);
    regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic pulseVblank();
    vblank = 1'b1; @(negedge clk); vblank = 1'b0;
  endtask

  task automatic pulseFb();
    fbWrite = 1'b1; @(negedge clk); fbWrite = 1'b0;
  endtask

  function automatic logic [31:0] word(bit on, logic [2:0] pol, bit entry, bit oneShot, bit abrt);
    return {23'b0, entry, oneShot, 2'b00, pol, abrt, on};
  endfunction

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    check("R1 readback", regRdData, 0);
    check("R1 state", srState, 0);
    check("R1 capture", captureFrame, 0);

    // R2 layout, R3/R4/R5 sweep over enable x policy
    for (int en = 0; en < 2; en++) begin
      for (int pol = 0; pol < 8; pol++) begin
        writeReg(32'h0); tick(1);
        writeReg(word(en[0], pol[2:0], 1'b1, 1'b0, 1'b0)); tick(1);
        check("R2 readback", regRdData, (1 << 8) | (pol << 2) | en);
        check("R4 sw entry", srState, (en == 1 && pol == 1) ? 1 : 0);
        writeReg(word(en[0], pol[2:0], 1'b0, 1'b0, 1'b0)); tick(1);
        check("R4 sw exit", srState, 0);
        for (int v = 0; v < IDLE_N - 1; v++) pulseVblank();
        tick(1);
        check("R5 one short", srState, 0);
        pulseVblank(); tick(1);
        check("R3 R5 hw entry", srState, (en == 1 && pol == 2) ? 1 : 0);
      end
    end

    // R2: reserved and abort bits read 0
    writeReg(32'hFFFF_FE61); tick(1);
    check("R2 reserved bits", regRdData & 32'hFFFF_FE62, 0);

    // R5: framebuffer write restarts count
    writeReg(32'h0); tick(1);
    writeReg(word(1'b1, 3'b010, 1'b0, 1'b0, 1'b0)); tick(1);
    for (int v = 0; v < IDLE_N - 1; v++) pulseVblank();
    pulseFb();
    for (int v = 0; v < IDLE_N - 1; v++) pulseVblank();
    tick(1);
    check("R5 count restarted", srState, 0);
    pulseVblank(); tick(1);
    check("R5 entry after restart", srState, 1);

    // R6: framebuffer write exits active
    pulseFb();
    check("R6 fb exit", srState, 0);

    // R7/R8/R9 one-shot in hardware policy from inactive
    writeReg(word(1'b1, 3'b010, 1'b0, 1'b1, 1'b0));
    check("R9 readback before vblank", regRdData[7], 0);
    tick(1);
    check("R7 sfu state", srState, 2);
    check("R7 capture first", captureFrame, 1);
    tick(1);
    check("R7 capture once", captureFrame, 0);
    check("R8 holds until vblank", srState, 2);
    check("R9 still old", regRdData[7], 0);
    pulseVblank();
    check("R8 back to active", srState, 1);
    check("R9 updated at vblank", regRdData[7], 1);

    // R9: clearing bit 7 shows only at vblank
    writeReg(word(1'b1, 3'b010, 1'b0, 1'b0, 1'b0)); tick(2);
    check("R9 clear pending", regRdData[7], 1);
    pulseVblank();
    check("R9 clear at vblank", regRdData[7], 0);

    // R7 in software policy from active
    writeReg(32'h0); tick(1);
    writeReg(word(1'b1, 3'b001, 1'b1, 1'b0, 1'b0)); tick(1);
    check("R4 sw active", srState, 1);
    writeReg(word(1'b1, 3'b001, 1'b1, 1'b1, 1'b0)); tick(1);
    check("R7 sw sfu", srState, 2);
    check("R7 sw capture", captureFrame, 1);
    pulseVblank(); pulseVblank();
    check("R8 sw back active", srState, 1);

    // R10 abort with entry still set
    writeReg(word(1'b1, 3'b001, 1'b1, 1'b0, 1'b1)); tick(1);
    check("R10 abort state", srState, 0);
    check("R10 abort reads 0", regRdData[1], 0);
    tick(3);
    check("R10 no re-entry", srState, 0);

    // R10 abort clears idle count in hardware policy
    writeReg(32'h0); tick(1);
    writeReg(word(1'b1, 3'b010, 1'b0, 1'b0, 1'b0)); tick(1);
    for (int v = 0; v < IDLE_N - 1; v++) pulseVblank();
    writeReg(word(1'b1, 3'b010, 1'b0, 1'b0, 1'b1)); tick(1);
    pulseVblank(); tick(1);
    check("R10 count cleared", srState, 0);

    // R7 one-shot ignored in manual policy
    writeReg(word(1'b1, 3'b000, 1'b0, 1'b1, 1'b0)); tick(1);
    check("R7 manual ignored state", srState, 0);
    check("R7 manual no capture", captureFrame, 0);
    tick(1);
    check("R7 manual no capture later", captureFrame, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule